// File: doc/BRIEF.md
# Ethernet PHY Management Register File

This block models the management register space of a minimal Ethernet transceiver as a management bus controller would see it. A requester presents a 5-bit register index with a read or write strobe and, for writes, a 16-bit data word. Read data comes back from an output register one clock after the read strobe. The serial bus framing is handled elsewhere. This block only answers indexed register accesses.

Most indices are plain 16-bit storage with fixed reset values. Three indices have no storage and are computed on every read. The status word reports fixed abilities and a link bit that follows the `link_i` input. The link-partner word always agrees with the locally advertised modes. A diagnostic word reports the resolved speed and duplex taken from the advertisement register at index 4. Because these three words are always derived, writes to their indices have no visible effect.

Top module: `phy_mgmt_regs`

## Requirements
- R1: After reset, index 0 reads 0x3100, index 2 reads 0x0300, index 3 reads 0xE400, index 4 (advertisement) reads 0x01E1, and every other storage index reads 0x0000.
- R2: `rvalid_o` is high in exactly the cycle after a cycle with `rd_i` high, and `rdata_o` carries the read word in that cycle. Both outputs are zero after reset.
- R3: Index 1 (status) reads 0x7828 with bit 2 equal to `link_i` in the strobe cycle. That is 0x782C with the link up and 0x7828 with the link down.
- R4: Index 5 (partner ability) reads 0x4000 ORed with advertisement bits 8:5 in the same positions; all other bits are 0.
- R5: In the index 18 diagnostic word, bit 10 is set when advertisement bit 7 (100 half) or bit 8 (100 full) is set.
- R6: In the index 18 diagnostic word, bit 11 is set when advertisement bit 8 (100 full) or bit 6 (10 full) is set; all other bits of that word are 0.
- R7: A write to any index other than 1, 5 and 18 stores all 16 bits, and a later read returns them.
- R8: Writes to indices 1, 5 and 18 do not change what those indices read back.
- R9: When a read and a write hit the same index in one cycle, the read returns the value held before that write.
- R10: `rdata_o` keeps its value in every cycle not preceded by a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| idx_i | input | 5 | Register index |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 16 | Write data |
| link_i | input | 1 | Link-up indication for the status word |
| rdata_o | output | 16 | Registered read data |
| rvalid_o | output | 1 | Read data valid, one cycle after `rd_i` |

## Verification
The advertisement register is loaded with several patterns before the derived words are read:
- Each single mode bit on its own (10 half, 10 full, 100 half, 100 full) shows which mode drives which diagnostic bit.
- The default value shows all modes combined.
- A pattern with every bit set except 8:5 shows that the partner copy is masked to exactly those bits.

The status word is read with the link input both high and low. All-ones writes to the derived indices show that those indices ignore writes. A read and a write to the same index in one cycle show whether the read returns the old or the new value.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned IDX_W  = 5;

  localparam int unsigned IDX_STATUS  = 1;
  localparam int unsigned IDX_ADVERT  = 4;
  localparam int unsigned IDX_PARTNER = 5;
  localparam int unsigned IDX_DIAG    = 18;

  function automatic logic is_derived(int unsigned idx);
    return (idx == IDX_STATUS) || (idx == IDX_PARTNER) || (idx == IDX_DIAG);
  endfunction

  function automatic logic [DATA_W-1:0] reset_val(int unsigned idx);
    case (idx)
      0:          return 16'h3100;
      2:          return 16'h0300;
      3:          return 16'hE400;
      IDX_ADVERT: return 16'h01E1;
      default:    return '0;
    endcase
  endfunction
endpackage

// File: rtl/phy_mgmt_store.sv
module phy_mgmt_store #(
  parameter int unsigned AW   = phy_mgmt_pkg::IDX_W,
  parameter int unsigned DW   = phy_mgmt_pkg::DATA_W,
  localparam int unsigned NREG = 1 << AW
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic [AW-1:0]            idx_i,
  input  logic [DW-1:0]            wdata_i,
  output logic [NREG-1:0][DW-1:0]  regs_o
);
  for (genvar gi = 0; gi < NREG; gi++) begin : g_reg
    if (phy_mgmt_pkg::is_derived(gi)) begin : g_none
      // derived words keep no state
      assign regs_o[gi] = '0;
    end else begin : g_ff
      logic [DW-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          q <= DW'(phy_mgmt_pkg::reset_val(gi));
        end else if (we_i && idx_i == AW'(gi)) begin
          q <= wdata_i;
        end
      end
      assign regs_o[gi] = q;
    end
  end
endmodule

// File: rtl/phy_mgmt_derive.sv
module phy_mgmt_derive #(
  parameter int unsigned DW = phy_mgmt_pkg::DATA_W
) (
  input  logic [3:0]    adv_i,   // advertisement bits 8:5
  input  logic          link_i,
  output logic [DW-1:0] status_o,
  output logic [DW-1:0] partner_o,
  output logic [DW-1:0] diag_o
);
  logic hd10, fd10, hd100, fd100;
  assign {fd100, hd100, fd10, hd10} = adv_i;

  always_comb begin
    status_o     = '0;
    status_o[14] = 1'b1;
    status_o[13] = 1'b1;
    status_o[12] = 1'b1;
    status_o[11] = 1'b1;
    status_o[5]  = 1'b1;  // negotiation complete
    status_o[3]  = 1'b1;  // negotiation able
    status_o[2]  = link_i;

    partner_o      = '0;
    partner_o[14]  = 1'b1;
    partner_o[8:5] = adv_i;

    diag_o     = '0;
    diag_o[10] = hd100 | fd100;
    diag_o[11] = fd100 | fd10;
  end
endmodule

// File: rtl/phy_mgmt_regs.sv
module phy_mgmt_regs #(
  parameter int unsigned AW = phy_mgmt_pkg::IDX_W,
  parameter int unsigned DW = phy_mgmt_pkg::DATA_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] idx_i,
  input  logic          rd_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          link_i,
  output logic [DW-1:0] rdata_o,
  output logic          rvalid_o
);
  localparam int unsigned NREG = 1 << AW;

  logic [NREG-1:0][DW-1:0] regs;
  logic [DW-1:0] status_w, partner_w, diag_w, rd_word;

  phy_mgmt_store #(.AW(AW), .DW(DW)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_i),
    .idx_i   (idx_i),
    .wdata_i (wdata_i),
    .regs_o  (regs)
  );

  phy_mgmt_derive #(.DW(DW)) u_derive (
    .adv_i     (regs[phy_mgmt_pkg::IDX_ADVERT][8:5]),
    .link_i    (link_i),
    .status_o  (status_w),
    .partner_o (partner_w),
    .diag_o    (diag_w)
  );

  always_comb begin
    if (idx_i == AW'(phy_mgmt_pkg::IDX_STATUS))       rd_word = status_w;
    else if (idx_i == AW'(phy_mgmt_pkg::IDX_PARTNER)) rd_word = partner_w;
    else if (idx_i == AW'(phy_mgmt_pkg::IDX_DIAG))    rd_word = diag_w;
    else                                              rd_word = regs[idx_i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
    end else begin
      rvalid_o <= rd_i;
      if (rd_i) rdata_o <= rd_word;
    end
  end
endmodule

// File: rtl/phy_mgmt_regs_chk.sv
module phy_mgmt_regs_chk #(
  parameter int unsigned AW = phy_mgmt_pkg::IDX_W,
  parameter int unsigned DW = phy_mgmt_pkg::DATA_W
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [AW-1:0] idx_i,
  input logic          rd_i,
  input logic          link_i,
  input logic [DW-1:0] rdata_o,
  input logic          rvalid_o
);
  a_r2_valid_after_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> rvalid_o);
  a_r2_no_spurious_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> !rvalid_o);
  a_r3_status_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && idx_i == AW'(1)) |=> (rdata_o == (16'h7828 | {13'd0, $past(link_i), 2'd0})));
  a_r4_partner_shape: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && idx_i == AW'(5)) |=> ((rdata_o & 16'hBE1F) == 16'h0000 && rdata_o[14]));
  a_r6_diag_shape: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && idx_i == AW'(18)) |=> ((rdata_o & 16'hF3FF) == 16'h0000));
  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rvalid_o |-> $stable(rdata_o));
endmodule

bind phy_mgmt_regs phy_mgmt_regs_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .idx_i    (idx_i),
  .rd_i     (rd_i),
  .link_i   (link_i),
  .rdata_o  (rdata_o),
  .rvalid_o (rvalid_o)
);

// File: tb/phy_mgmt_regs_bench.sv
module phy_mgmt_regs_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [4:0]  idx_i = '0;
  logic        rd_i = 1'b0;
  logic        wr_i = 1'b0;
  logic [15:0] wdata_i = '0;
  logic        link_i = 1'b1;
  logic [15:0] rdata_o;
  logic        rvalid_o;

  int checks = 0;
  int errors = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];
  logic [15:0] adv = 16'h01E1;

  always #2 clk = ~clk;

  phy_mgmt_regs u_phy_mgmt_regs (
    .clk_i(clk), .rst_ni(rst_ni), .idx_i(idx_i), .rd_i(rd_i), .wr_i(wr_i),
    .wdata_i(wdata_i), .link_i(link_i), .rdata_o(rdata_o), .rvalid_o(rvalid_o)
  );

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] f_status(logic l);
    return 16'h7828 | (l ? 16'h0004 : 16'h0000);
  endfunction
  function automatic logic [15:0] f_partner(logic [15:0] a);
    return 16'h4000 | (a & 16'h01E0);
  endfunction
  function automatic logic [15:0] f_diag(logic [15:0] a);
    logic [15:0] d = '0;
    d[10] = a[7] | a[8];
    d[11] = a[8] | a[6];
    return d;
  endfunction

  // monitor: pop expected word for every valid response
  always @(negedge clk) begin
    if (rst_ni && rvalid_o) begin
      if (exp_q.size() == 0) begin
        chk("R2 unexpected rvalid", 16'h0001, 16'h0000);
      end else begin
        chk(tag_q.pop_front(), rdata_o, exp_q.pop_front());
      end
    end
  end

  task automatic do_read(logic [4:0] i, logic [15:0] e, string tag);
    @(negedge clk);
    idx_i = i; rd_i = 1'b1; wr_i = 1'b0;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    rd_i = 1'b0;
  endtask

  task automatic do_write(logic [4:0] i, logic [15:0] d);
    @(negedge clk);
    idx_i = i; wr_i = 1'b1; rd_i = 1'b0; wdata_i = d;
    if (i == 5'd4) adv = d;
    @(negedge clk);
    wr_i = 1'b0;
  endtask

  task automatic do_rw(logic [4:0] i, logic [15:0] d, logic [15:0] e, string tag);
    @(negedge clk);
    idx_i = i; wr_i = 1'b1; rd_i = 1'b1; wdata_i = d;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    wr_i = 1'b0; rd_i = 1'b0;
  endtask

  task automatic adv_case(logic [15:0] a);
    do_write(5'd4, a);
    do_read(5'd5, f_partner(a), "R4 partner");
    do_read(5'd18, f_diag(a), "R5 R6 diag");
  endtask

  initial begin
    logic [15:0] held;
    #1;
    chk("R2 reset rvalid", {15'd0, rvalid_o}, 16'h0000);
    chk("R2 reset rdata", rdata_o, 16'h0000);
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;

    do_read(5'd0, 16'h3100, "R1 idx0");
    do_read(5'd2, 16'h0300, "R1 idx2");
    do_read(5'd3, 16'hE400, "R1 idx3");
    do_read(5'd4, 16'h01E1, "R1 idx4");
    do_read(5'd6, 16'h0000, "R1 idx6");
    do_read(5'd31, 16'h0000, "R1 idx31");

    link_i = 1'b1;
    do_read(5'd1, f_status(1'b1), "R3 link up");
    link_i = 1'b0;
    do_read(5'd1, f_status(1'b0), "R3 link down");
    link_i = 1'b1;

    do_read(5'd5, f_partner(adv), "R4 partner default");
    do_read(5'd18, f_diag(adv), "R5 R6 diag default");
    adv_case(16'h0020);
    adv_case(16'h0040);
    adv_case(16'h0080);
    adv_case(16'h0100);
    adv_case(16'hFE1F);
    adv_case(16'h0180);

    do_write(5'd7, 16'hA5C3);
    do_write(5'd31, 16'h5A3C);
    do_read(5'd7, 16'hA5C3, "R7 idx7");
    do_read(5'd31, 16'h5A3C, "R7 idx31");
    do_write(5'd0, 16'hFFFF);
    do_read(5'd0, 16'hFFFF, "R7 idx0");

    do_write(5'd1, 16'hFFFF);
    do_write(5'd5, 16'hFFFF);
    do_write(5'd18, 16'hFFFF);
    do_read(5'd1, f_status(1'b1), "R8 status");
    do_read(5'd5, f_partner(adv), "R8 partner");
    do_read(5'd18, f_diag(adv), "R8 diag");

    do_write(5'd9, 16'h1111);
    do_rw(5'd9, 16'h2222, 16'h1111, "R9 old value");
    do_read(5'd9, 16'h2222, "R9 new value");

    @(negedge clk);
    held = rdata_o;
    idx_i = 5'd0; wr_i = 1'b1; wdata_i = 16'h0BAD; link_i = 1'b0;
    @(negedge clk);
    wr_i = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 hold", rdata_o, held);
    chk("R2 idle rvalid", {15'd0, rvalid_o}, 16'h0000);
    chk("R2 queue drained", 16'(exp_q.size()), 16'h0000);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #100000;
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule